// File: doc/BRIEF.md
# Programmable LCD Timing Generator

This block drives the timing side of a parallel RGB panel: horizontal and vertical sync, data-enable, the current pixel position inside the visible area, and four auxiliary panel-control strobes. All geometry is held in word-addressed 32-bit registers and is measured from the first clock of each sync pulse. Each timing register carries a pair of 10-bit positions: the start position in the upper half-word and the end position in the lower half-word.

Software programs the geometry and sets the enable bit. While the generator runs, changes to the geometry and polarity registers are held back until the next frame boundary. Start-of-frame and end-of-frame events set sticky status flags, and each flag can raise an interrupt output. A disable request lets the current frame finish. The generator then parks every output at its inactive level and reports that it has stopped.

Top module: `lcd_timing_gen`

## Requirements
- R1: Word addresses: 0 config, 1 vsync pair, 2 hsync pair, 3 totals (line total in [31:16], frame total in [15:0]), 4 horizontal active pair, 5 vertical active pair, 6..9 strobe pairs 0..3, 12 control, 13 status. Every other address reads 0. In a pair register the start position is held in [25:16] and the end position in [9:0], and only those bits read back. Config keeps only bits [23:20] and [15:8]. Control keeps only bits 13, 12, 4 and 3.
- R2: The horizontal counter runs from 0 to line total − 1. The vertical counter advances when the horizontal counter wraps and runs from 0 to frame total − 1. Position 0 is the first clock of the sync pulse. Hsync is active while start ≤ h < end, and vsync is active while start ≤ v < end.
- R3: Data-enable is active while h lies in the horizontal active window and v lies in the vertical active window. Each window includes its start and excludes its end.
- R4: While data-enable is active, pix_x_o equals h minus the horizontal active start and pix_y_o equals v minus the vertical active start. At all other times both read 0.
- R5: Config bit 11 inverts hsync, bit 8 inverts vsync and bit 9 inverts data-enable. Bit 10 is copied to pclk_fall_o.
- R6: One cycle after control bit 3 reads 1 with bit 4 at 0, the generator starts with both counters at 0.
- R7: Strobe i is active while strobe-start ≤ h < strobe-end. Config bit 20+i forces strobe i inactive, and config bit 12+i inverts it.
- R8: While control bit 4 is set, the generator completes the current frame and then stops. After it stops, all outputs sit at their inactive level, status bit 0 reads 1, and control bits 3 and 4 read 0. Status bit 0 reads 0 while the generator runs.
- R9: Status bit 4 is set on the first cycle of each frame (h = 0, v = 0). Status bit 5 is set on the last cycle of each frame. Writing status clears each flag whose written bit is 0. A flag event in the same cycle wins over the clear.
- R10: irq_sof_o is status bit 4 gated by control bit 12. irq_eof_o is status bit 5 gated by control bit 13.
- R11: Geometry and config written while the generator runs take effect only on the cycle after a frame's last cycle. While the generator is stopped they apply at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel-rate clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | One-cycle register write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data-enable |
| pclk_fall_o | output | 1 | Falling pixel-clock edge select |
| pix_x_o | output | 10 | Column inside the active area |
| pix_y_o | output | 10 | Row inside the active area |
| strobe_o | output | 4 | Auxiliary panel strobes |
| irq_sof_o | output | 1 | Start-of-frame interrupt |
| irq_eof_o | output | 1 | End-of-frame interrupt |

## Verification
A counter that is off by one shows up at the ports on the next clock, as a sync, data-enable, strobe or pixel-position edge one cycle early or late. The bench compares every output on every cycle, so it reports such a fault within a line. A shadow register that reloads at the wrong time puts the new geometry on the pins before the frame boundary, and the bench rewrites the timing in the middle of a frame to expose this. A faulty stop sequence leaves the status bit or the control bits wrong on the read port in the cycle after the last pixel of the frame.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
  localparam int ADDR_W = 4;

  localparam int A_CFG   = 0;
  localparam int A_PAIR0 = 1;
  localparam int A_CTRL  = 12;
  localparam int A_STAT  = 13;

  // pair index, address = A_PAIR0 + index
  localparam int PR_VS   = 0;
  localparam int PR_HS   = 1;
  localparam int PR_TOT  = 2;
  localparam int PR_HA   = 3;
  localparam int PR_VA   = 4;
  localparam int PR_STB0 = 5;

  localparam int CFG_VS_LOW  = 8;
  localparam int CFG_DE_LOW  = 9;
  localparam int CFG_FALL    = 10;
  localparam int CFG_HS_LOW  = 11;
  localparam int CFG_STB_POL = 12;
  localparam int CFG_STB_OFF = 20;

  localparam int CT_EN     = 3;
  localparam int CT_DIS    = 4;
  localparam int CT_IE_SOF = 12;
  localparam int CT_IE_EOF = 13;

  localparam int ST_OFF = 0;
  localparam int ST_SOF = 4;
  localparam int ST_EOF = 5;

  localparam logic [31:0] CFG_MASK  = 32'h00F0_FF00;
  localparam logic [31:0] CTRL_MASK = 32'h0000_3018;
endpackage

// File: rtl/lcd_tg_window.sv
module lcd_tg_window #(
  parameter int POS_W = 10
) (
  input  logic [POS_W-1:0] pos_i,
  input  logic [POS_W-1:0] start_i,
  input  logic [POS_W-1:0] end_i,
  output logic             hit_o
);
  assign hit_o = (pos_i >= start_i) && (pos_i < end_i);
endmodule

// File: rtl/lcd_tg_regs.sv
module lcd_tg_regs
  import lcd_tg_pkg::*;
#(
  parameter int POS_W = 10,
  parameter int NPAIR = 9
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [31:0]                     wdata_i,
  input  logic                            run_i,
  input  logic                            stop_i,
  input  logic                            sof_evt_i,
  input  logic                            eof_evt_i,
  output logic [31:0]                     cfg_o,
  output logic [31:0]                     ctrl_o,
  output logic [NPAIR-1:0][1:0][POS_W-1:0] pair_o,
  output logic                            flag_sof_o,
  output logic                            flag_eof_o,
  output logic [31:0]                     rdata_o
);
  localparam int PAD_W = 16 - POS_W;

  logic [31:0] cfg_q, ctrl_q;
  logic [NPAIR-1:0][1:0][POS_W-1:0] pair_q;
  logic flag_sof_q, flag_eof_q;
  logic wr_cfg, wr_ctrl, wr_stat;

  assign wr_cfg  = we_i && (addr_i == ADDR_W'(A_CFG));
  assign wr_ctrl = we_i && (addr_i == ADDR_W'(A_CTRL));
  assign wr_stat = we_i && (addr_i == ADDR_W'(A_STAT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else if (wr_cfg) cfg_q <= wdata_i & CFG_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (stop_i) begin
      ctrl_q[CT_EN]  <= 1'b0;
      ctrl_q[CT_DIS] <= 1'b0;
    end else if (wr_ctrl) ctrl_q <= wdata_i & CTRL_MASK;
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic wr_p;
    assign wr_p = we_i && (addr_i == ADDR_W'(A_PAIR0 + p));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pair_q[p] <= '0;
      else if (wr_p) begin
        pair_q[p][1] <= wdata_i[16 +: POS_W];
        pair_q[p][0] <= wdata_i[0 +: POS_W];
      end
    end
  end

  // clear-by-zero; an event in the same cycle wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_sof_q <= 1'b0;
      flag_eof_q <= 1'b0;
    end else begin
      flag_sof_q <= (flag_sof_q & (~wr_stat | wdata_i[ST_SOF])) | sof_evt_i;
      flag_eof_q <= (flag_eof_q & (~wr_stat | wdata_i[ST_EOF])) | eof_evt_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(A_CFG))  rdata_o = cfg_q;
    if (addr_i == ADDR_W'(A_CTRL)) rdata_o = ctrl_q;
    if (addr_i == ADDR_W'(A_STAT)) begin
      rdata_o[ST_OFF] = ~run_i;
      rdata_o[ST_SOF] = flag_sof_q;
      rdata_o[ST_EOF] = flag_eof_q;
    end
    for (int p = 0; p < NPAIR; p++) begin
      if (addr_i == ADDR_W'(A_PAIR0 + p))
        rdata_o = {{PAD_W{1'b0}}, pair_q[p][1], {PAD_W{1'b0}}, pair_q[p][0]};
    end
  end

  assign cfg_o      = cfg_q;
  assign ctrl_o     = ctrl_q;
  assign pair_o     = pair_q;
  assign flag_sof_o = flag_sof_q;
  assign flag_eof_o = flag_eof_q;
endmodule

// File: rtl/lcd_tg_core.sv
module lcd_tg_core
  import lcd_tg_pkg::*;
#(
  parameter int POS_W = 10,
  parameter int NPAIR = 9
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            en_i,
  input  logic                            dis_i,
  input  logic [31:0]                     cfg_i,
  input  logic [NPAIR-1:0][1:0][POS_W-1:0] pair_i,
  output logic                            run_o,
  output logic                            stop_o,
  output logic                            frame_last_o,
  output logic                            sof_o,
  output logic [POS_W-1:0]                h_o,
  output logic [POS_W-1:0]                v_o,
  output logic [31:0]                     cfg_sh_o,
  output logic [NPAIR-1:0][1:0][POS_W-1:0] pair_sh_o
);
  logic run_q;
  logic [POS_W-1:0] h_q, v_q;
  logic [31:0] cfg_sh_q;
  logic [NPAIR-1:0][1:0][POS_W-1:0] pair_sh_q;
  logic h_last, v_last, frame_last, start, stop, load;

  assign h_last     = ({1'b0, h_q} + 1'b1) >= {1'b0, pair_sh_q[PR_TOT][1]};
  assign v_last     = ({1'b0, v_q} + 1'b1) >= {1'b0, pair_sh_q[PR_TOT][0]};
  assign frame_last = run_q && h_last && v_last;
  assign start      = !run_q && en_i && !dis_i;
  assign stop       = frame_last && dis_i;
  assign load       = !run_q || frame_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      h_q   <= '0;
      v_q   <= '0;
    end else if (start) begin
      run_q <= 1'b1;
      h_q   <= '0;
      v_q   <= '0;
    end else if (run_q) begin
      if (stop) begin
        run_q <= 1'b0;
        h_q   <= '0;
        v_q   <= '0;
      end else if (h_last) begin
        h_q <= '0;
        v_q <= v_last ? '0 : v_q + 1'b1;
      end else begin
        h_q <= h_q + 1'b1;
      end
    end
  end

  // geometry is latched only between frames
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_sh_q  <= '0;
      pair_sh_q <= '0;
    end else if (load) begin
      cfg_sh_q  <= cfg_i;
      pair_sh_q <= pair_i;
    end
  end

  assign run_o        = run_q;
  assign stop_o       = stop;
  assign frame_last_o = frame_last;
  assign sof_o        = run_q && (h_q == '0) && (v_q == '0);
  assign h_o          = h_q;
  assign v_o          = v_q;
  assign cfg_sh_o     = cfg_sh_q;
  assign pair_sh_o    = pair_sh_q;
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_tg_pkg::*;
#(
  parameter int POS_W = 10,
  parameter int NSTB  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic              pclk_fall_o,
  output logic [POS_W-1:0]  pix_x_o,
  output logic [POS_W-1:0]  pix_y_o,
  output logic [NSTB-1:0]   strobe_o,
  output logic              irq_sof_o,
  output logic              irq_eof_o
);
  localparam int NPAIR = PR_STB0 + NSTB;

  logic [31:0] cfg, ctrl, cfg_sh;
  logic [NPAIR-1:0][1:0][POS_W-1:0] pair, pair_sh;
  logic flag_sof, flag_eof;
  logic run, stop, frame_last, sof_evt;
  logic [POS_W-1:0] h_cnt, v_cnt;
  logic hit_hs, hit_vs, hit_ha, hit_va, de_act;
  logic [NSTB-1:0] hit_stb;

  lcd_tg_regs #(.POS_W(POS_W), .NPAIR(NPAIR)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .run_i(run), .stop_i(stop), .sof_evt_i(sof_evt), .eof_evt_i(frame_last),
    .cfg_o(cfg), .ctrl_o(ctrl), .pair_o(pair),
    .flag_sof_o(flag_sof), .flag_eof_o(flag_eof), .rdata_o
  );

  lcd_tg_core #(.POS_W(POS_W), .NPAIR(NPAIR)) u_core (
    .clk_i, .rst_ni, .en_i(ctrl[CT_EN]), .dis_i(ctrl[CT_DIS]),
    .cfg_i(cfg), .pair_i(pair),
    .run_o(run), .stop_o(stop), .frame_last_o(frame_last), .sof_o(sof_evt),
    .h_o(h_cnt), .v_o(v_cnt), .cfg_sh_o(cfg_sh), .pair_sh_o(pair_sh)
  );

  lcd_tg_window #(.POS_W(POS_W)) u_win_hs (
    .pos_i(h_cnt), .start_i(pair_sh[PR_HS][1]), .end_i(pair_sh[PR_HS][0]), .hit_o(hit_hs));
  lcd_tg_window #(.POS_W(POS_W)) u_win_vs (
    .pos_i(v_cnt), .start_i(pair_sh[PR_VS][1]), .end_i(pair_sh[PR_VS][0]), .hit_o(hit_vs));
  lcd_tg_window #(.POS_W(POS_W)) u_win_ha (
    .pos_i(h_cnt), .start_i(pair_sh[PR_HA][1]), .end_i(pair_sh[PR_HA][0]), .hit_o(hit_ha));
  lcd_tg_window #(.POS_W(POS_W)) u_win_va (
    .pos_i(v_cnt), .start_i(pair_sh[PR_VA][1]), .end_i(pair_sh[PR_VA][0]), .hit_o(hit_va));

  for (genvar s = 0; s < NSTB; s++) begin : g_stb
    lcd_tg_window #(.POS_W(POS_W)) u_win_stb (
      .pos_i(h_cnt), .start_i(pair_sh[PR_STB0+s][1]), .end_i(pair_sh[PR_STB0+s][0]),
      .hit_o(hit_stb[s]));
    assign strobe_o[s] = (run & hit_stb[s] & ~cfg_sh[CFG_STB_OFF+s]) ^ cfg_sh[CFG_STB_POL+s];
  end

  assign de_act      = run & hit_ha & hit_va;
  assign hsync_o     = (run & hit_hs) ^ cfg_sh[CFG_HS_LOW];
  assign vsync_o     = (run & hit_vs) ^ cfg_sh[CFG_VS_LOW];
  assign de_o        = de_act ^ cfg_sh[CFG_DE_LOW];
  assign pclk_fall_o = cfg_sh[CFG_FALL];
  assign pix_x_o     = de_act ? h_cnt - pair_sh[PR_HA][1] : '0;
  assign pix_y_o     = de_act ? v_cnt - pair_sh[PR_VA][1] : '0;
  assign irq_sof_o   = flag_sof & ctrl[CT_IE_SOF];
  assign irq_eof_o   = flag_eof & ctrl[CT_IE_EOF];
endmodule

// File: rtl/lcd_tg_chk.sv
module lcd_tg_chk
  import lcd_tg_pkg::*;
#(
  parameter int POS_W = 10,
  parameter int NPAIR = 9
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            run,
  input logic                            frame_last,
  input logic [POS_W-1:0]                h_cnt,
  input logic [POS_W-1:0]                v_cnt,
  input logic [31:0]                     ctrl,
  input logic [31:0]                     cfg_sh,
  input logic [NPAIR-1:0][1:0][POS_W-1:0] pair_sh,
  input logic                            flag_sof,
  input logic                            hsync_o,
  input logic                            de_o,
  input logic [POS_W-1:0]                pix_x_o,
  input logic                            irq_sof_o,
  input logic                            irq_eof_o
);
  // R2
  h_in_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && (pair_sh[PR_TOT][1] != '0) |-> h_cnt < pair_sh[PR_TOT][1]);
  // R6
  start_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run) |-> (h_cnt == '0) && (v_cnt == '0));
  // R8
  stop_on_request_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run) |-> $past(ctrl[CT_DIS]) && !ctrl[CT_EN] && !ctrl[CT_DIS]);
  // R8
  idle_hsync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> hsync_o == cfg_sh[CFG_HS_LOW]);
  // R4
  pix_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (de_o == cfg_sh[CFG_DE_LOW]) |-> pix_x_o == '0);
  // R9
  sof_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_sof) |-> $past(run && (h_cnt == '0) && (v_cnt == '0)));
  // R10
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_sof_o |-> ctrl[CT_IE_SOF]) and (irq_eof_o |-> ctrl[CT_IE_EOF]));
  // R11
  shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && $past(run) && !$past(frame_last) |-> $stable(pair_sh) && $stable(cfg_sh));
endmodule

bind lcd_timing_gen lcd_tg_chk #(.POS_W(POS_W), .NPAIR(NPAIR)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run(run), .frame_last(frame_last),
  .h_cnt(h_cnt), .v_cnt(v_cnt), .ctrl(ctrl), .cfg_sh(cfg_sh), .pair_sh(pair_sh),
  .flag_sof(flag_sof), .hsync_o(hsync_o), .de_o(de_o), .pix_x_o(pix_x_o),
  .irq_sof_o(irq_sof_o), .irq_eof_o(irq_eof_o)
);

// File: tb/lcd_timing_gen_tb.sv
module lcd_timing_gen_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic hs, vs, de, fall, irq_s, irq_e;
  logic [9:0] px, py;
  logic [3:0] stb;

  always #4 clk = ~clk;

  lcd_timing_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .hsync_o(hs), .vsync_o(vs), .de_o(de), .pclk_fall_o(fall),
    .pix_x_o(px), .pix_y_o(py), .strobe_o(stb), .irq_sof_o(irq_s), .irq_eof_o(irq_e)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // behavioural model state
  int m_cfg = 0, m_ctrl = 0, s_cfg = 0;
  int m_pr[9][2], s_pr[9][2];
  int m_run = 0, m_h = 0, m_v = 0, m_fs = 0, m_fe = 0;

  task automatic chk(string rq, string nm, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s at %0t: actual %0h expected %0h", rq, nm, $time, act, exp);
    end
  endtask

  function automatic int m_read(int a);
    if (a == 0) return m_cfg;
    if (a == 12) return m_ctrl;
    if (a == 13) return (m_fe << 5) | (m_fs << 4) | (m_run ? 0 : 1);
    if (a >= 1 && a <= 9) return (m_pr[a-1][1] << 16) | m_pr[a-1][0];
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cfg = 0; m_ctrl = 0; s_cfg = 0; m_run = 0; m_h = 0; m_v = 0; m_fs = 0; m_fe = 0;
      for (int p = 0; p < 9; p++) begin
        m_pr[p][0] = 0; m_pr[p][1] = 0; s_pr[p][0] = 0; s_pr[p][1] = 0;
      end
    end else begin
      int ht, vt, hl, vl, last, sof, go, halt, ld;
      ht = s_pr[2][1]; vt = s_pr[2][0];
      hl = (m_h + 1 >= ht); vl = (m_v + 1 >= vt);
      last = m_run && hl && vl;
      sof = m_run && m_h == 0 && m_v == 0;
      go = !m_run && m_ctrl[3] && !m_ctrl[4];
      halt = last && m_ctrl[4];
      ld = !m_run || last;
      if (ld) begin
        s_cfg = m_cfg;
        for (int p = 0; p < 9; p++) begin s_pr[p][0] = m_pr[p][0]; s_pr[p][1] = m_pr[p][1]; end
      end
      if (we && addr == 13) begin
        if (!wdata[4]) m_fs = 0;
        if (!wdata[5]) m_fe = 0;
      end
      if (sof) m_fs = 1;
      if (last) m_fe = 1;
      if (halt) m_ctrl = m_ctrl & ~32'h18;
      else if (we && addr == 12) m_ctrl = wdata & 32'h3018;
      if (we && addr == 0) m_cfg = wdata & 32'h00F0FF00;
      if (we && addr >= 1 && addr <= 9) begin
        m_pr[addr-1][1] = (wdata >> 16) & 32'h3FF;
        m_pr[addr-1][0] = wdata & 32'h3FF;
      end
      if (go) begin m_run = 1; m_h = 0; m_v = 0; end
      else if (m_run) begin
        if (halt) begin m_run = 0; m_h = 0; m_v = 0; end
        else if (hl) begin m_h = 0; m_v = vl ? 0 : m_v + 1; end
        else m_h = m_h + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int hsa, vsa, dea, e;
      hsa = m_run && m_h >= s_pr[1][1] && m_h < s_pr[1][0];
      vsa = m_run && m_v >= s_pr[0][1] && m_v < s_pr[0][0];
      dea = m_run && m_h >= s_pr[3][1] && m_h < s_pr[3][0] && m_v >= s_pr[4][1] && m_v < s_pr[4][0];
      chk("R2", "hsync", hs, hsa ^ s_cfg[11]);
      chk("R2", "vsync", vs, vsa ^ s_cfg[8]);
      chk("R3", "de", de, dea ^ s_cfg[9]);
      chk("R5", "pclk_fall", fall, s_cfg[10]);
      chk("R4", "pix_x", px, dea ? (m_h - s_pr[3][1]) & 32'h3FF : 0);
      chk("R4", "pix_y", py, dea ? (m_v - s_pr[4][1]) & 32'h3FF : 0);
      for (int s = 0; s < 4; s++) begin
        e = (m_run && m_h >= s_pr[5+s][1] && m_h < s_pr[5+s][0] && !s_cfg[20+s]) ^ s_cfg[12+s];
        chk("R7", $sformatf("strobe%0d", s), stb[s], e);
      end
      chk("R10", "irq_sof", irq_s, m_fs & m_ctrl[12]);
      chk("R10", "irq_eof", irq_e, m_fe & m_ctrl[13]);
      chk("R1", "rdata", rdata, m_read(addr));
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk); #1;
    we = 1'b1; addr = 4'(a); wdata = d;
    @(negedge clk); #1;
    we = 1'b0; addr = 4'd13;
  endtask

  task automatic idle(int n, int a);
    @(negedge clk); #1;
    addr = 4'(a);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_stop();
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (rdata[0]) break;
    end
    // R8: stopped status and cleared control bits
    chk("R8", "status_off", rdata[0], 1);
    idle(1, 12);
    chk("R8", "ctrl_after_stop", rdata & 32'h18, 0);
    chk("R8", "de_idle", de, m_cfg[9]);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1, 13);
    chk("R8", "reset_status", rdata, 1);
    // geometry: line 20, frame 8
    wr(1, 32'h0000_0002);
    wr(2, 32'h0000_0003);
    wr(3, 32'h0014_0008);
    wr(4, 32'h0005_0011);
    wr(5, 32'h0003_0007);
    wr(6, 32'h0006_0009);
    wr(7, 32'h0000_0001);
    wr(8, 32'h000A_000F);
    wr(9, 32'h0012_0014);
    wr(0, 32'hFF20_40FF);  // R7: strobe1 off, strobe2 inverted; stray bits dropped
    for (int a = 0; a < 16; a++) idle(1, a);
    wr(12, 32'hFFFF_1008); // R6 enable with sof irq
    idle(170, 13);
    // R11: mid-frame geometry and polarity change
    wr(2, 32'h0001_0005);
    wr(0, 32'h0020_4F00);
    idle(200, 2);
    wr(13, 0);             // R9 clear both flags
    wr(12, 32'h0000_3008);
    idle(100, 13);
    wr(13, 32'h10);        // R9 clear eof only
    idle(60, 13);
    wr(12, 32'h0000_3018); // R8 disable request
    wait_stop();
    idle(20, 13);
    // tiny frame corner: line 4, frame 3
    wr(3, 32'h0004_0003);
    wr(4, 32'h0001_0003);
    wr(5, 32'h0000_0002);
    wr(0, 32'h0);
    wr(12, 32'h0000_3008);
    idle(50, 13);
    wr(12, 32'h0000_0018);
    wait_stop();
    idle(10, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule